// File: doc/BRIEF.md
# Windowed IF Frequency Counter

This block decides whether an intermediate-frequency signal sits close enough to its expected value to stop a station search. Once the synthesizer reports lock and software enables counting, it opens a gate of a programmable number of clock cycles. During the gate, each IF cycle (delivered as a one-clock tick, already synchronised to `clk`) decrements a down counter. The counter was preloaded with a mode constant plus a small centre trim. When the counter passes through zero it wraps and reloads itself.

A correct IF makes the wrap land at the end of the gate. The block accepts the measurement when the wrap falls within a selectable number of IF cycles before or after the gate end, and it then raises `search_stop`. Three modes are supported: FM, AM upconversion and AM. The mode sets the base gate time and the preload constant, and a 3-bit select stretches the base gate by a power of two.

Each qualification of lock and enable runs exactly one measurement. The result is held until the next measurement starts. Losing lock or the enable part way through throws the measurement away.

Top module: `if_window_counter`

## Requirements
- R1: After reset, `search_stop` is 0 and the block is idle.
- R2: A measurement starts on a clock edge where the block is idle and both `pll_locked` and `count_en` are 1. At that edge `search_stop` is cleared, and the mode, gate select, centre trim and window select are taken from the inputs. With either qualifier low, no measurement starts and `search_stop` keeps its value.
- R3: The gate covers the `BASE << gate_sel` clock edges that follow the start edge, and only ticks sampled on those edges are counted. BASE is `FM_BASE_CLKS` for mode code 0 (FM) and mode code 3 (treated as FM). BASE is `AM_BASE_CLKS` for mode code 1 (AM upconversion) and mode code 2 (AM).
- R4: The preload P is `centre_trim` plus `K_FM` (codes 0 and 3), `K_AMUP` (code 1) or `K_AM` (code 2). The counter wraps on the (P+1)-th counted tick and reloads P.
- R5: Let E = 2^`win_sel` (1, 2, 4 or 8) and let N be the number of ticks counted in the gate. The measurement passes exactly when |N − (P+1)| ≤ E.
- R6: `search_stop` takes the result on the clock edge that follows the last gate edge, and at no other edge does it go high.
- R7: If `pll_locked` or `count_en` is 0 during the gate or at the result edge, the measurement is aborted, `search_stop` goes to 0 on that edge, and the block returns to idle.
- R8: After the result edge, `search_stop` keeps its value until the next measurement starts, whatever the qualifiers and ticks do.
- R9: After a result, no new measurement starts until the qualifiers have dropped and risen again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pll_locked | input | 1 | Synthesizer lock indication |
| count_en | input | 1 | Software enable for the counter |
| mode | input | 2 | 0 = FM, 1 = AM upconversion, 2 = AM, 3 = FM |
| gate_sel | input | SEL_W | Gate stretch: gate = base << gate_sel |
| centre_trim | input | CF_W | Trim added to the mode preload constant |
| win_sel | input | EW_W | Tolerance E = 2^win_sel IF cycles |
| if_tick | input | 1 | One-clock pulse per IF cycle, synchronous |
| search_stop | output | 1 | High when the last measurement fell inside the window |

## Verification
The gate starts at the edge that starts the measurement. Ticks are counted on each of the next `BASE << gate_sel` edges, and the result appears one edge after the last gate edge. The bench therefore drives the tick for each gate edge on the falling edge before that edge. It also drives ticks on the start edge and on the result edge, where they must be ignored; this exposes a gate that is off by one cycle in either direction. The bench reads `search_stop` on the falling edge just before the result edge, where it must still be 0, and again on the falling edge just after, where it must match |N − (P+1)| ≤ E. Hold, abort and no-start behaviour are read on falling edges one or more cycles after the qualifying edge.

// File: rtl/ifwc_pkg.sv
package ifwc_pkg;
   typedef enum logic [1:0] {
      MODE_FM   = 2'd0,
      MODE_AMUP = 2'd1,
      MODE_AM   = 2'd2,
      MODE_RSV  = 2'd3
   } ifwc_mode_e;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_GATE = 2'd1,
      ST_EVAL = 2'd2,
      ST_DONE = 2'd3
   } ifwc_state_e;
endpackage

// File: rtl/ifwc_gate_timer.sv
module ifwc_gate_timer #(
   parameter int unsigned GATE_W = 24
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              abort,
   input  logic [GATE_W-1:0] len,
   output logic              active,
   output logic              last
);
   logic [GATE_W-1:0] rem;

   assign last = active && (rem == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rem    <= '0;
         active <= 1'b0;
      end else if (abort) begin
         active <= 1'b0;
      end else if (load) begin
         rem    <= len - GATE_W'(1);
         active <= 1'b1;
      end else if (active) begin
         if (rem == '0) active <= 1'b0;
         else           rem    <= rem - GATE_W'(1);
      end
   end

   AST_GATE_SINGLE_END: assert property (@(posedge clk) disable iff (!rst_n)
      last |=> !last); // R3
   AST_GATE_LEN_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
      load |-> (len != '0)); // R3
endmodule

// File: rtl/ifwc_down_counter.sv
module ifwc_down_counter #(
   parameter int unsigned CNT_W   = 21,
   parameter int unsigned SINCE_W = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load,
   input  logic [CNT_W-1:0]   preload,
   input  logic               tick,
   output logic [CNT_W-1:0]   cnt,
   output logic               uf_seen,
   output logic [SINCE_W-1:0] since_uf
);
   localparam logic [SINCE_W-1:0] SINCE_MAX = '1;

   logic [CNT_W-1:0] preload_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt       <= '0;
         preload_q <= '0;
         uf_seen   <= 1'b0;
         since_uf  <= '0;
      end else if (load) begin
         cnt       <= preload;
         preload_q <= preload;
         uf_seen   <= 1'b0;
         since_uf  <= '0;
      end else if (tick) begin
         if (cnt == '0) cnt <= preload_q;
         else           cnt <= cnt - CNT_W'(1);
         if (uf_seen) begin
            if (since_uf != SINCE_MAX) since_uf <= since_uf + SINCE_W'(1);
         end else if (cnt == '0) begin
            uf_seen <= 1'b1;
         end
      end
   end

   AST_WRAP_RELOADS: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !load && cnt == '0) |=> (cnt == $past(preload_q) && uf_seen)); // R4
endmodule

// File: rtl/ifwc_window_judge.sv
module ifwc_window_judge #(
   parameter int unsigned CNT_W   = 21,
   parameter int unsigned EW_W    = 2,
   parameter int unsigned SINCE_W = 4
) (
   input  logic [CNT_W-1:0]   cnt,
   input  logic               uf_seen,
   input  logic [SINCE_W-1:0] since_uf,
   input  logic [EW_W-1:0]    win_sel,
   output logic               pass
);
   logic [CNT_W-1:0]   tol_cnt;
   logic [SINCE_W-1:0] tol_since;

   always_comb begin
      tol_cnt   = CNT_W'(1) << win_sel;
      tol_since = SINCE_W'(1) << win_sel;
      if (uf_seen) pass = (since_uf <= tol_since);
      else         pass = (cnt < tol_cnt);
   end
endmodule

// File: rtl/if_window_counter.sv
module if_window_counter
   import ifwc_pkg::*;
#(
   parameter int unsigned CNT_W        = 21,
   parameter int unsigned CF_W         = 5,
   parameter int unsigned EW_W         = 2,
   parameter int unsigned SEL_W        = 3,
   parameter int unsigned FM_BASE_CLKS = 8000,
   parameter int unsigned AM_BASE_CLKS = 50000,
   parameter int unsigned K_FM         = 1697,
   parameter int unsigned K_AMUP       = 10689,
   parameter int unsigned K_AM         = 489
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pll_locked,
   input  logic             count_en,
   input  logic [1:0]       mode,
   input  logic [SEL_W-1:0] gate_sel,
   input  logic [CF_W-1:0]  centre_trim,
   input  logic [EW_W-1:0]  win_sel,
   input  logic             if_tick,
   output logic             search_stop
);
   localparam int unsigned MAX_BASE = (FM_BASE_CLKS > AM_BASE_CLKS) ? FM_BASE_CLKS : AM_BASE_CLKS;
   localparam int unsigned MAX_SHIFT = (2 ** SEL_W) - 1;
   localparam int unsigned GATE_W   = $clog2(MAX_BASE) + MAX_SHIFT + 1;
   localparam int unsigned MAX_TOL  = 2 ** ((2 ** EW_W) - 1);
   localparam int unsigned SINCE_W  = $clog2(MAX_TOL + 2);
   localparam int unsigned MAX_K    = (K_AMUP > K_FM) ? ((K_AMUP > K_AM) ? K_AMUP : K_AM)
                                                      : ((K_FM > K_AM) ? K_FM : K_AM);

   generate
      if (MAX_K + (2 ** CF_W) >= (2 ** CNT_W)) begin : g_bad_cnt_w
         $error("counter width too small for preload");
      end
      if (FM_BASE_CLKS == 0 || AM_BASE_CLKS == 0) begin : g_bad_base
         $error("base gate lengths must be nonzero");
      end
      if (CNT_W < 2 || EW_W < 1 || SEL_W < 1) begin : g_bad_widths
         $error("field widths out of range");
      end
   endgenerate

   ifwc_state_e       state;
   logic              go, start, abort, pass;
   logic              gate_active, gate_last;
   logic [GATE_W-1:0] base_len, gate_len;
   logic [CNT_W-1:0]  preload, cnt;
   logic              uf_seen;
   logic [SINCE_W-1:0] since_uf;
   logic [EW_W-1:0]   ew_q;

   assign go    = pll_locked && count_en;
   assign start = (state == ST_IDLE) && go;
   assign abort = ((state == ST_GATE) || (state == ST_EVAL)) && !go;

   always_comb begin
      case (ifwc_mode_e'(mode))
         MODE_AMUP: begin
            base_len = GATE_W'(AM_BASE_CLKS);
            preload  = CNT_W'(K_AMUP) + CNT_W'(centre_trim);
         end
         MODE_AM: begin
            base_len = GATE_W'(AM_BASE_CLKS);
            preload  = CNT_W'(K_AM) + CNT_W'(centre_trim);
         end
         default: begin
            base_len = GATE_W'(FM_BASE_CLKS);
            preload  = CNT_W'(K_FM) + CNT_W'(centre_trim);
         end
      endcase
      gate_len = base_len << gate_sel;
   end

   ifwc_gate_timer #(.GATE_W(GATE_W)) u_gate (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (start),
      .abort  (abort),
      .len    (gate_len),
      .active (gate_active),
      .last   (gate_last)
   );

   ifwc_down_counter #(.CNT_W(CNT_W), .SINCE_W(SINCE_W)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (start),
      .preload  (preload),
      .tick     ((state == ST_GATE) && gate_active && if_tick),
      .cnt      (cnt),
      .uf_seen  (uf_seen),
      .since_uf (since_uf)
   );

   ifwc_window_judge #(.CNT_W(CNT_W), .EW_W(EW_W), .SINCE_W(SINCE_W)) u_judge (
      .cnt      (cnt),
      .uf_seen  (uf_seen),
      .since_uf (since_uf),
      .win_sel  (ew_q),
      .pass     (pass)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state       <= ST_IDLE;
         search_stop <= 1'b0;
         ew_q        <= '0;
      end else begin
         case (state)
            ST_IDLE: if (go) begin
               state       <= ST_GATE;
               search_stop <= 1'b0;
               ew_q        <= win_sel;
            end
            ST_GATE: begin
               if (!go) begin
                  state       <= ST_IDLE;
                  search_stop <= 1'b0;
               end else if (gate_last) begin
                  state <= ST_EVAL;
               end
            end
            ST_EVAL: begin
               if (!go) begin
                  state       <= ST_IDLE;
                  search_stop <= 1'b0;
               end else begin
                  state       <= ST_DONE;
                  search_stop <= pass;
               end
            end
            default: if (!go) state <= ST_IDLE;
         endcase
      end
   end

   AST_CLEAR_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IDLE && go) |=> (!search_stop && state == ST_GATE)); // R2
   AST_IDLE_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IDLE && !go) |=> (state == ST_IDLE && $stable(search_stop))); // R2
   AST_RISE_AT_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(search_stop) |-> $past(state == ST_EVAL)); // R6
   AST_ABORT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      ((state == ST_GATE || state == ST_EVAL) && !go) |=> (!search_stop && state == ST_IDLE)); // R7
   AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_DONE) |=> $stable(search_stop)); // R8
   AST_ONE_PER_QUALIFY: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_DONE && go) |=> (state == ST_DONE)); // R9
endmodule

// File: tb/if_window_counter_tb.sv
module if_window_counter_tb;
   localparam int FM_B = 8, AM_B = 20, KF = 20, KU = 60, KA = 12;

   logic       clk = 1'b0, rst_n = 1'b0;
   logic       pll_locked = 1'b0, count_en = 1'b0, if_tick = 1'b0;
   logic [1:0] mode = 2'd0;
   logic [2:0] gate_sel = 3'd0;
   logic [4:0] centre_trim = 5'd0;
   logic [1:0] win_sel = 2'd0;
   logic       search_stop;
   int         n_chk = 0, n_bad = 0;
   bit         finished = 1'b0;

   always #10 clk = ~clk;

   if_window_counter #(
      .FM_BASE_CLKS(FM_B), .AM_BASE_CLKS(AM_B),
      .K_FM(KF), .K_AMUP(KU), .K_AM(KA)
   ) u_dut (
      .clk(clk), .rst_n(rst_n), .pll_locked(pll_locked), .count_en(count_en),
      .mode(mode), .gate_sel(gate_sel), .centre_trim(centre_trim),
      .win_sel(win_sel), .if_tick(if_tick), .search_stop(search_stop)
   );

   function automatic int k_of(int m);
      return (m == 1) ? KU : (m == 2) ? KA : KF;
   endfunction

   function automatic int glen(int m, int s);
      return ((m == 1 || m == 2) ? AM_B : FM_B) << s;
   endfunction

   function automatic bit exp_pass(int p, int n, int ew);
      int e = 1 << ew;
      if (n < p + 1) return (p + 1 - n) <= e;
      return (n - (p + 1)) <= e;
   endfunction

   task automatic chk(string tag, logic act, logic exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: search_stop=%0b expected %0b at %0t", tag, act, exp, $time);
      end
   endtask

   // one measurement with exactly n ticks spread over the gate
   task automatic run_meas(int m, int s, int cf, int ew, int n, string tag);
      int g = glen(m, s);
      int p = k_of(m) + cf;
      int left = n;
      @(negedge clk);
      mode = 2'(m); gate_sel = 3'(s); centre_trim = 5'(cf); win_sel = 2'(ew);
      pll_locked = 1'b1; count_en = 1'b1; if_tick = 1'b1; // ignored on start edge
      @(posedge clk);
      for (int i = 0; i < g; i++) begin
         @(negedge clk);
         if (i == 0) chk({tag, " R2 cleared at start"}, search_stop, 1'b0);
         if_tick = (($urandom % (g - i)) < left) ? 1'b1 : 1'b0;
         if (if_tick) left--;
      end
      @(negedge clk);
      if_tick = 1'b1; // ignored on result edge
      chk({tag, " R6 not before result edge"}, search_stop, 1'b0);
      @(negedge clk);
      if_tick = 1'b0;
      chk({tag, " R5 window decision"}, search_stop, exp_pass(p, n, ew));
   endtask

   task automatic gap_hold(logic exp);
      @(negedge clk);
      count_en = 1'b0;
      if_tick = 1'b1;
      @(negedge clk);
      @(negedge clk);
      if_tick = 1'b0;
      chk("R8 held after qualifiers drop", search_stop, exp);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: run did not finish, actual hung expected done");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd1234));
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R1 reset value", search_stop, 1'b0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 idle after reset", search_stop, 1'b0);

      // R5 exact hit, boundaries either side
      run_meas(0, 4, 5, 0, 26, "R5 exact");          gap_hold(1'b1);
      run_meas(0, 4, 5, 1, 28, "R5 late edge pass"); gap_hold(1'b1);
      run_meas(0, 4, 5, 1, 29, "R5 late edge fail"); gap_hold(1'b0);
      run_meas(2, 3, 10, 3, 15, "R5 early edge pass R4 AM"); gap_hold(1'b1);
      run_meas(2, 3, 10, 3, 14, "R5 early edge fail R4 AM"); gap_hold(1'b0);
      run_meas(1, 4, 31, 2, 96, "R4 AM-up pass");   gap_hold(1'b1);
      run_meas(1, 4, 31, 2, 97, "R4 AM-up fail");   gap_hold(1'b0);
      // R3 gate length: tick on every gate edge, P+1 equals gate length
      run_meas(0, 2, 11, 0, 32, "R3 full gate FM");  gap_hold(1'b1);
      run_meas(3, 2, 11, 0, 32, "R3 code 3 as FM");  gap_hold(1'b1);
      run_meas(2, 1, 27, 0, 40, "R3 full gate AM");  gap_hold(1'b1);

      // R9 / R8: qualifiers stay high after a result, ticks keep coming
      run_meas(0, 3, 0, 0, 21, "R9 setup");
      repeat (80) begin
         @(negedge clk);
         if_tick = 1'($urandom % 2);
      end
      @(negedge clk);
      if_tick = 1'b0;
      chk("R9 no restart while qualified", search_stop, 1'b1);

      // R2: lock low blocks a start, flag kept
      @(negedge clk);
      pll_locked = 1'b0; count_en = 1'b0;
      @(negedge clk);
      count_en = 1'b1;
      repeat (40) begin
         @(negedge clk);
         if_tick = 1'($urandom % 2);
      end
      if_tick = 1'b0;
      chk("R2 no start without lock", search_stop, 1'b1);

      // R7: abort mid gate
      @(negedge clk);
      count_en = 1'b0;
      @(negedge clk);
      mode = 2'd0; gate_sel = 3'd4; centre_trim = 5'd0; win_sel = 2'd0;
      pll_locked = 1'b1; count_en = 1'b1;
      repeat (10) begin
         @(negedge clk);
         if_tick = 1'b1;
      end
      pll_locked = 1'b0;
      @(negedge clk);
      chk("R7 abort on lock loss", search_stop, 1'b0);
      if_tick = 1'b0;
      @(negedge clk);
      count_en = 1'b0;
      run_meas(0, 3, 2, 1, 23, "R7 recovery after abort"); gap_hold(1'b1);

      // random mix
      for (int it = 0; it < 40; it++) begin
         int m  = int'($urandom % 4);
         int s  = 3 + int'($urandom % 3);
         int cf = int'($urandom % 32);
         int ew = int'($urandom % 4);
         int g  = glen(m, s);
         int n  = k_of(m) + cf + 1 + int'($urandom % 25) - 12;
         if (n < 0) n = 0;
         if (n > g) n = g;
         run_meas(m, s, cf, ew, n, "R5 random");
         gap_hold(exp_pass(k_of(m) + cf, n, ew));
      end

      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule